// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access controller. Software programs a control word, a 16-bit item count, a peripheral-side address and a memory-side address. The channel then moves data items one at a time. Each item is one read from the source side, then one write of that data to the destination side, over a single-beat bus master port. In peripheral-paced mode one item is moved per request from the peripheral, and each item is acknowledged back to it. In memory-to-memory mode the items run back to back and no request is needed.

Each side has its own address pointer. When the side's increment bit is set, the pointer steps by that side's item size after each item. The count falls by one per item. In normal mode the channel then sits with a zero count until software disables it, reloads the count and enables it again. In circular mode the count and both pointers return to their programmed values, and the transfer goes on. The channel raises pulses on completion, on half completion and on a bus error. A single interrupt line combines these pulses through per-event enable bits.

The sequencer has four states. IDLE waits to launch. READ holds the read beat. WRITE holds the write beat. STEP is the bookkeeping cycle. Transitions: IDLE to READ when the channel is enabled, the count is nonzero, and either memory-to-memory mode is on or a request is present. READ to WRITE on a read acknowledge. WRITE to STEP on a write acknowledge. STEP to IDLE always. READ to IDLE and WRITE to IDLE on a bus error response.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, all four registers read as zero and the channel raises no bus request, no acknowledge and no event.
- R2: Each completed item lowers the count by one. In normal mode the count reads zero after the last item, and the done event pulses once.
- R3: The half event pulses on the item after which the remaining count equals the programmed count shifted right by one.
- R4: A write to the count register while the enable bit is set leaves the count unchanged.
- R5: An enabled channel with a zero count issues no bus request. A new transfer starts after software clears enable, writes a count and sets enable again.
- R6: When memory-to-memory mode is off, one item moves per peripheral request, with a one-cycle per_ack pulse per item. With no request pending, nothing moves.
- R7: When memory-to-memory mode is on, items run back to back with no request until the count reaches zero.
- R8: Pointers load from the programmed addresses when enable rises. After each item a side's pointer advances by 1, 2 or 4 bytes for size code 0, 1 or 2 if its increment bit is set, and otherwise stays fixed. The direction bit selects which side is read.
- R9: In circular mode, the item that would bring the count to zero reloads it with the programmed count. The same item restores both pointers to the programmed addresses. The done event still pulses.
- R10: A bus error on either beat clears the enable bit, pulses the error event, leaves the count unchanged and ends the item.
- R11: irq is high in a cycle exactly when an event pulses whose enable bit is set.
- R12: Register index 0 is the control word, 1 the count, 2 the peripheral address and 3 the memory address. The control word bits are: bit 0 enable, 1 memory-to-memory, 2 circular, 3 direction (1 means memory is the source), 4 peripheral increment, 5 memory increment, 7:6 peripheral size, 9:8 memory size, 11:10 priority, 12 done interrupt enable, 13 half interrupt enable, 14 error interrupt enable. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| per_req | input | 1 | Peripheral request |
| per_ack | output | 1 | Item-done acknowledge to the peripheral |
| bus_req | output | 1 | Bus beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Beat byte address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Beat completed |
| bus_err | input | 1 | Beat failed |
| evt_done | output | 1 | Transfer complete pulse |
| evt_half | output | 1 | Half transfer pulse |
| evt_err | output | 1 | Transfer error pulse |
| irq | output | 1 | Enabled events combined |

## Verification
The bench counts events across a circular run of five items on a count of three. This catches a channel that fails to reload its pointers: it would write past the buffer instead of overwriting the first byte. It also catches half events that are not repeated on the second pass. A count written while enabled must still read zero, and a zero-count enabled channel must never raise a request. An engine that ignored the lock or launched on zero would move spurious data. A failing write beat must leave the enable bit clear, the count untouched and the destination unchanged. A fixed-address half-word move must not disturb the neighbouring byte, which exposes a wrong size or a wrong stride.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    // Register indices on the configuration port
    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_PADDR = 2'd2;
    localparam logic [1:0] REG_MADDR = 2'd3;

    // Control word, bit 0 (en) is the least significant field
    typedef struct packed {
        logic       ie_err;
        logic       ie_half;
        logic       ie_done;
        logic [1:0] prio;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       minc;
        logic       pinc;
        logic       mem_src;
        logic       circ;
        logic       m2m;
        logic       en;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_READ  = 2'd1,
        FSM_WRITE = 2'd2,
        FSM_STEP  = 2'd3
    } xfer_state_e;

    // Byte stride for a size code; code 3 behaves as a word
    function automatic logic [2:0] stride_of(input logic [1:0] sz);
        unique case (sz)
            2'd0:    stride_of = 3'd1;
            2'd1:    stride_of = 3'd2;
            default: stride_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              item_done,
    input  logic              err_stop,
    output chan_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] pbase,
    output logic [ADDR_W-1:0] mbase,
    output logic              en_rise,
    output logic              reload,
    output logic              last_item,
    output logic              half_hit
);

    chan_ctrl_t       ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] init_q;
    logic [ADDR_W-1:0] pbase_q;
    logic [ADDR_W-1:0] mbase_q;
    logic             cnt_wr_ok;
    logic             cnt_nz;

    assign cnt_nz    = (cnt_q != '0);
    assign en_rise   = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0] && !ctrl_q.en;
    assign cnt_wr_ok = cfg_we && (cfg_addr == REG_COUNT) && !ctrl_q.en;
    assign last_item = (cnt_q == CNT_W'(1));
    assign reload    = item_done && ctrl_q.circ && last_item;
    assign half_hit  = cnt_nz && ((cnt_q - CNT_W'(1)) == (init_q >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            init_q  <= '0;
            pbase_q <= '0;
            mbase_q <= '0;
        end else begin
            if (cfg_we && (cfg_addr == REG_CTRL))
                ctrl_q <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (err_stop)
                ctrl_q.en <= 1'b0;
            if (cnt_wr_ok) begin
                cnt_q  <= cfg_wdata[CNT_W-1:0];
                init_q <= cfg_wdata[CNT_W-1:0];
            end else if (item_done && cnt_nz) begin
                cnt_q <= reload ? init_q : cnt_q - CNT_W'(1);
            end
            if (cfg_we && (cfg_addr == REG_PADDR))
                pbase_q <= cfg_wdata;
            if (cfg_we && (cfg_addr == REG_MADDR))
                mbase_q <= cfg_wdata;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            REG_CTRL:  cfg_rdata = ADDR_W'(ctrl_q);
            REG_COUNT: cfg_rdata = ADDR_W'(cnt_q);
            REG_PADDR: cfg_rdata = pbase_q;
            default:   cfg_rdata = mbase_q;
        endcase
    end

    assign ctrl  = ctrl_q;
    assign cnt   = cnt_q;
    assign pbase = pbase_q;
    assign mbase = mbase_q;

    // The count holds still against writes while the channel runs
    assert_cnt_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr == REG_COUNT) && ctrl_q.en && !item_done) |=> (cnt_q == $past(cnt_q)));

    // A wrapping item leaves the count at its programmed value
    assert_reload_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == init_q));

    // An ordinary item lowers the count by exactly one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (item_done && !reload && cnt_nz && !cnt_wr_ok) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              reload,
    input  logic              step,
    input  logic              pinc,
    input  logic              minc,
    input  logic [1:0]        psize,
    input  logic [1:0]        msize,
    input  logic [ADDR_W-1:0] pbase,
    input  logic [ADDR_W-1:0] mbase,
    output logic [ADDR_W-1:0] cur_p,
    output logic [ADDR_W-1:0] cur_m
);

    localparam int SIDES = 2;

    logic [ADDR_W-1:0] base_s [SIDES];
    logic              inc_s  [SIDES];
    logic [1:0]        size_s [SIDES];
    logic [ADDR_W-1:0] ptr_s  [SIDES];

    assign base_s[0] = pbase;
    assign base_s[1] = mbase;
    assign inc_s[0]  = pinc;
    assign inc_s[1]  = minc;
    assign size_s[0] = psize;
    assign size_s[1] = msize;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic [ADDR_W-1:0] ptr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (load || reload)
                ptr_q <= base_s[s];
            else if (step && inc_s[s])
                ptr_q <= ptr_q + ADDR_W'(stride_of(size_s[s]));
        end

        assign ptr_s[s] = ptr_q;

        // A side without increment keeps its address across items
        assert_fixed_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !inc_s[s] && !load && !reload) |=> $stable(ptr_q));
    end

    assign cur_p = ptr_s[0];
    assign cur_m = ptr_s[1];

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              m2m,
    input  logic              mem_src,
    input  logic [1:0]        psize,
    input  logic [1:0]        msize,
    input  logic              cnt_zero,
    input  logic              last_item,
    input  logic              half_hit,
    input  logic              per_req,
    input  logic [ADDR_W-1:0] cur_p,
    input  logic [ADDR_W-1:0] cur_m,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              item_done,
    output logic              err_stop,
    output logic              per_ack,
    output logic              evt_done,
    output logic              evt_half,
    output logic              evt_err
);

    xfer_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [1:0]        src_size, dst_size;
    logic              launch;

    assign src_addr = mem_src ? cur_m : cur_p;
    assign dst_addr = mem_src ? cur_p : cur_m;
    assign src_size = mem_src ? msize : psize;
    assign dst_size = mem_src ? psize : msize;
    assign launch   = en && !cnt_zero && (m2m || per_req);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE:  if (launch) state_d = FSM_READ;
            FSM_READ:  if (bus_err) state_d = FSM_IDLE;
                       else if (bus_ack) state_d = FSM_WRITE;
            FSM_WRITE: if (bus_err) state_d = FSM_IDLE;
                       else if (bus_ack) state_d = FSM_STEP;
            FSM_STEP:  state_d = FSM_IDLE;
            default:   state_d = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == FSM_READ) && bus_ack && !bus_err)
                data_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_size  = 2'd0;
        item_done = 1'b0;
        err_stop  = 1'b0;
        per_ack   = 1'b0;
        evt_done  = 1'b0;
        evt_half  = 1'b0;
        evt_err   = 1'b0;
        unique case (state_q)
            FSM_IDLE: ;
            FSM_READ: begin
                bus_req  = 1'b1;
                bus_addr = src_addr;
                bus_size = src_size;
                err_stop = bus_err;
                evt_err  = bus_err;
            end
            FSM_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst_addr;
                bus_size = dst_size;
                err_stop = bus_err;
                evt_err  = bus_err;
            end
            FSM_STEP: begin
                item_done = 1'b1;
                per_ack   = !m2m;
                evt_done  = last_item;
                evt_half  = half_hit;
            end
            default: ;
        endcase
    end

    assign bus_wdata = data_q;

    // Zero count: the channel never leaves IDLE
    assert_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FSM_IDLE) && cnt_zero) |=> (state_q == FSM_IDLE));

    // Peripheral-paced mode needs a request to launch
    assert_need_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FSM_IDLE) && !m2m && !per_req) |=> (state_q == FSM_IDLE));

    // Memory-to-memory mode launches with no request
    assert_m2m_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FSM_IDLE) && en && m2m && !cnt_zero) |=> (state_q == FSM_READ));

    // An error response ends the item at once
    assert_err_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == FSM_READ) || (state_q == FSM_WRITE)) && bus_err) |=> (state_q == FSM_IDLE));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              evt_done,
    output logic              evt_half,
    output logic              evt_err,
    output logic              irq
);

    chan_ctrl_t        ctrl;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] pbase, mbase, cur_p, cur_m;
    logic              en_rise, reload, last_item, half_hit;
    logic              item_done, err_stop;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .item_done (item_done),
        .err_stop  (err_stop),
        .ctrl      (ctrl),
        .cnt       (cnt),
        .pbase     (pbase),
        .mbase     (mbase),
        .en_rise   (en_rise),
        .reload    (reload),
        .last_item (last_item),
        .half_hit  (half_hit)
    );

    dma_chan_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (en_rise),
        .reload (reload),
        .step   (item_done),
        .pinc   (ctrl.pinc),
        .minc   (ctrl.minc),
        .psize  (ctrl.psize),
        .msize  (ctrl.msize),
        .pbase  (pbase),
        .mbase  (mbase),
        .cur_p  (cur_p),
        .cur_m  (cur_m)
    );

    dma_chan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .m2m       (ctrl.m2m),
        .mem_src   (ctrl.mem_src),
        .psize     (ctrl.psize),
        .msize     (ctrl.msize),
        .cnt_zero  (cnt == '0),
        .last_item (last_item),
        .half_hit  (half_hit),
        .per_req   (per_req),
        .cur_p     (cur_p),
        .cur_m     (cur_m),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .item_done (item_done),
        .err_stop  (err_stop),
        .per_ack   (per_ack),
        .evt_done  (evt_done),
        .evt_half  (evt_half),
        .evt_err   (evt_err)
    );

    assign irq = (evt_done && ctrl.ie_done) || (evt_half && ctrl.ie_half) || (evt_err && ctrl.ie_err);

    // An error leaves the channel disabled
    assert_err_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |=> !ctrl.en);

    // A normal-mode completion leaves a zero count
    assert_done_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !ctrl.circ && ctrl.en) |=> (cnt == '0));

endmodule

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        bus_req, bus_we, bus_ack, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        evt_done, evt_half, evt_err, irq;

    logic [7:0]  mem [0:255];
    logic        bad_en = 1'b0;
    logic [31:0] bad_addr = '0;

    int total = 0;
    int bad = 0;
    int n_done = 0, n_half = 0, n_err = 0, n_irq = 0, n_ack = 0;

    always #4 clk = ~clk;

    dma_chan_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .evt_done(evt_done), .evt_half(evt_half), .evt_err(evt_err), .irq(irq)
    );

    // Byte-addressed little-endian memory slave answering in the same cycle
    logic [7:0] ba;
    assign ba        = bus_addr[7:0];
    assign bus_err   = bus_req && bad_en && (bus_addr == bad_addr);
    assign bus_ack   = bus_req && !bus_err;
    assign bus_rdata = {mem[ba + 8'd3], mem[ba + 8'd2], mem[ba + 8'd1], mem[ba]};

    always @(posedge clk) begin
        if (bus_req && bus_we && bus_ack) begin
            mem[ba] <= bus_wdata[7:0];
            if (bus_size != 2'd0) mem[ba + 8'd1] <= bus_wdata[15:8];
            if (bus_size[1]) begin
                mem[ba + 8'd2] <= bus_wdata[23:16];
                mem[ba + 8'd3] <= bus_wdata[31:24];
            end
        end
    end

    always @(negedge clk) begin
        if (evt_done) n_done++;
        if (evt_half) n_half++;
        if (evt_err)  n_err++;
        if (irq)      n_irq++;
        if (per_ack)  n_ack++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        per_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (per_ack) break;
        end
        per_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int r = 0; r < 4; r++) begin
            reg_rd(2'(r), v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 idle outputs", {31'b0, bus_req | per_ack | evt_done | evt_half | evt_err | irq}, 32'h0);
    endtask

    task automatic t_m2m_words();
        logic [31:0] v;
        int miss = 0;
        int d0 = n_done, h0 = n_half, i0 = n_irq;
        reg_wr(2'd2, 32'h40);
        reg_wr(2'd3, 32'h80);
        reg_wr(2'd1, 32'd4);
        reg_wr(2'd0, 32'h2B3);
        repeat (40) @(negedge clk);
        for (int i = 0; i < 16; i++) if (mem[8'h80 + 8'(i)] !== 8'(8'h10 + i)) miss++;
        chk("R7 R8 m2m word copy mismatches", miss, 0);
        reg_rd(2'd1, v);
        chk("R2 count after normal completion", v, 32'd0);
        chk("R2 done pulses", n_done - d0, 1);
        chk("R3 half pulses (count 4)", n_half - h0, 1);
        chk("R11 no irq with enables off", n_irq - i0, 0);
        reg_rd(2'd0, v);
        chk("R12 control readback", v, 32'h2B3);
    endtask

    task automatic t_count_lock();
        logic [31:0] v;
        int reqs = 0;
        int miss = 0;
        reg_wr(2'd1, 32'd9);
        reg_rd(2'd1, v);
        chk("R4 count write while enabled", v, 32'd0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (bus_req) reqs++;
        end
        chk("R5 no bus request at zero count", reqs, 0);
        reg_wr(2'd0, 32'h2B2);
        reg_wr(2'd1, 32'd2);
        reg_rd(2'd1, v);
        chk("R4 count write while disabled", v, 32'd2);
        reg_wr(2'd2, 32'h50);
        reg_wr(2'd3, 32'h90);
        reg_wr(2'd0, 32'h2B3);
        repeat (30) @(negedge clk);
        for (int i = 0; i < 8; i++) if (mem[8'h90 + 8'(i)] !== 8'(8'h20 + i)) miss++;
        chk("R5 restart after reload", miss, 0);
    endtask

    task automatic t_periph_bytes();
        logic [31:0] v;
        int a0 = n_ack, d0 = n_done;
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd2, 32'h20);
        reg_wr(2'd3, 32'hA0);
        reg_wr(2'd1, 32'd3);
        reg_wr(2'd0, 32'h21);
        repeat (20) @(negedge clk);
        reg_rd(2'd1, v);
        chk("R6 nothing moves without request", v, 32'd3);
        chk("R6 destination untouched", {24'b0, mem[8'hA0]}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            mem[8'h20] = 8'(8'hB0 + k);
            pulse_req();
        end
        repeat (4) @(negedge clk);
        chk("R6 per_ack pulses", n_ack - a0, 3);
        chk("R8 fixed source, stepping dest", {mem[8'hA2], mem[8'hA1], mem[8'hA0]}, 32'hB2B1B0);
        reg_rd(2'd1, v);
        chk("R2 count after requests", v, 32'd0);
        chk("R2 done pulse periph mode", n_done - d0, 1);
    endtask

    task automatic t_mem_src_half();
        int h0 = n_half, i0 = n_irq;
        for (int i = 0; i < 6; i++) mem[8'hC0 + 8'(i)] = 8'(8'h61 + i);
        mem[8'h30] = 8'h0; mem[8'h31] = 8'h0; mem[8'h32] = 8'h0;
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd2, 32'h30);
        reg_wr(2'd3, 32'hC0);
        reg_wr(2'd1, 32'd3);
        reg_wr(2'd0, 32'h116B);
        repeat (30) @(negedge clk);
        chk("R8 half-word to fixed peripheral", {16'b0, mem[8'h31], mem[8'h30]}, 32'h6665);
        chk("R8 neighbour byte untouched", {24'b0, mem[8'h32]}, 32'h0);
        chk("R3 half pulse (count 3)", n_half - h0, 1);
        chk("R11 irq only for done", n_irq - i0, 1);
    endtask

    task automatic t_circular();
        logic [31:0] v;
        int d0 = n_done, h0 = n_half;
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd2, 32'h20);
        reg_wr(2'd3, 32'hE0);
        reg_wr(2'd1, 32'd3);
        reg_wr(2'd0, 32'h25);
        for (int k = 0; k < 5; k++) begin
            mem[8'h20] = 8'(8'h70 + k);
            pulse_req();
        end
        repeat (4) @(negedge clk);
        chk("R9 wrapped buffer contents", {8'b0, mem[8'hE2], mem[8'hE1], mem[8'hE0]}, 32'h727473);
        chk("R9 byte past buffer untouched", {24'b0, mem[8'hE3]}, 32'h0);
        reg_rd(2'd1, v);
        chk("R9 count after reload", v, 32'd1);
        chk("R9 done pulses", n_done - d0, 1);
        chk("R3 half pulses across wrap", n_half - h0, 2);
    endtask

    task automatic t_bus_error();
        logic [31:0] v;
        int e0 = n_err, i0 = n_irq;
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd2, 32'h48);
        reg_wr(2'd3, 32'hF0);
        reg_wr(2'd1, 32'd2);
        bad_addr = 32'hF0;
        bad_en = 1'b1;
        reg_wr(2'd0, 32'h42B3);
        repeat (20) @(negedge clk);
        reg_rd(2'd0, v);
        chk("R10 enable cleared", v, 32'h42B2);
        reg_rd(2'd1, v);
        chk("R10 count unchanged", v, 32'd2);
        chk("R10 error pulse", n_err - e0, 1);
        chk("R10 destination unwritten", {24'b0, mem[8'hF0]}, 32'h0);
        chk("R11 irq on enabled error", n_irq - i0, 1);
        bad_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h0;
        for (int i = 0; i < 32; i++) mem[8'h40 + 8'(i)] = 8'(8'h10 + i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_m2m_words();
        t_count_lock();
        t_periph_bytes();
        t_mem_src_half();
        t_circular();
        t_bus_error();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule